// File: doc/BRIEF.md
# Global Comparator Timer

A 64-bit free-running timer with a 64-bit compare unit and a level interrupt, reached through a simple single-cycle register bus. The counter advances once per clock while it is enabled. Software can preset it one 32-bit half at a time, and reads it as high, low, high to get a consistent 64-bit value.

An event is raised when the counter is at or beyond the comparator, not only when the two are exactly equal. With auto-increment on, each event adds a programmed step to the comparator, which gives periodic ticks. The event flag is cleared by writing a one to it, and the interrupt output shows the flag gated by its enable. Once an event has fired for a comparator value, the flag cannot set again until the comparator is rewritten or advanced. This lets a handler clear the flag while the counter is still past the compare point.

Bus reads are combinational in the cycle of the access. Writes take effect at the clock edge that ends the access.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero and the interrupt is low. Reads of an unmapped offset (for example 0x1C) return zero, and writes to an unmapped offset change no register.
- R2: Byte offsets on the bus: 0x00 counter bits 31:0, 0x04 counter bits 63:32, 0x08 control, 0x0C status, 0x10 comparator bits 31:0, 0x14 comparator bits 63:32, 0x18 auto-increment step. The control bits are: bit 0 count enable, bit 1 compare enable, bit 2 interrupt enable, bit 3 auto-increment enable.
- R3: While count enable is set, the 64-bit counter grows by one at every clock edge, and a carry out of the low half appears in the high half at the same edge. While count enable is clear, the counter holds.
- R4: A write to either counter half loads that half and leaves the other half unchanged. During that edge the write replaces the increment.
- R5: The event flag (status bit 0) sets at the clock edge that follows a cycle in which count enable and compare enable are both set and the counter is greater than or equal to the comparator.
- R6: Writing 1 to status bit 0 clears the flag, and writing 0 to it has no effect.
- R7: After an event without auto-increment, the flag does not set again while the comparator is unchanged. A write to either comparator half re-arms the compare, which is then evaluated in the following cycle.
- R8: When an event fires with auto-increment enabled, the comparator grows by the step at that same edge, and events repeat every step counts.
- R9: The interrupt output equals the event flag ANDed with interrupt enable.
- R10: While compare enable is clear, writes to the comparator never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the cycle of the access |
| irqOut | output | 1 | Level interrupt |

## Verification
A write lands at the edge that closes the access, so a readback of the counter or control is correct at the following falling edge. A compare hit is registered, so the flag and the interrupt show up one edge after the cycle in which the counter reaches the comparator. The bench counts edges from the write that enabled counting, and it samples the flag both in the cycle before and in the cycle it is due. Each auto-increment period in the sweep is measured the same way, by reading the comparator in the cycle the flag rises. Unmapped accesses, writes of zero to the status bit and comparator writes while compare is disabled are each checked at the ports right after they happen.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int OFS_CNT_LO = 'h00;
  localparam int OFS_CNT_HI = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_STAT   = 'h0C;
  localparam int OFS_CMP_LO = 'h10;
  localparam int OFS_CMP_HI = 'h14;
  localparam int OFS_STEP   = 'h18;

  typedef enum logic [2:0] {
    RS_NONE, RS_CNT_LO, RS_CNT_HI, RS_CTRL, RS_STAT, RS_CMP_LO, RS_CMP_HI, RS_STEP
  } rdSel_e;

  typedef struct packed {
    logic aEn;
    logic iEn;
    logic cEn;
    logic tEn;
  } ctrlBits_t;

  typedef struct packed {
    logic   cntLoWr;
    logic   cntHiWr;
    logic   cmpLoWr;
    logic   cmpHiWr;
    logic   stepWr;
    logic   flagClr;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        wrBits,
  output strobe_t           stb,
  output ctrlBits_t         ctrl
);
  logic wrEn;
  logic ctrlWr;

  assign wrEn   = busSel && busWr;
  assign ctrlWr = wrEn && (busAddr == ADDR_W'(OFS_CTRL));

  always_comb begin
    stb         = '0;
    stb.rdSel   = RS_NONE;
    stb.cntLoWr = wrEn && (busAddr == ADDR_W'(OFS_CNT_LO));
    stb.cntHiWr = wrEn && (busAddr == ADDR_W'(OFS_CNT_HI));
    stb.cmpLoWr = wrEn && (busAddr == ADDR_W'(OFS_CMP_LO));
    stb.cmpHiWr = wrEn && (busAddr == ADDR_W'(OFS_CMP_HI));
    stb.stepWr  = wrEn && (busAddr == ADDR_W'(OFS_STEP));
    stb.flagClr = wrEn && (busAddr == ADDR_W'(OFS_STAT)) && wrBits[0];
    if (busSel) begin
      case (busAddr)
        ADDR_W'(OFS_CNT_LO): stb.rdSel = RS_CNT_LO;
        ADDR_W'(OFS_CNT_HI): stb.rdSel = RS_CNT_HI;
        ADDR_W'(OFS_CTRL):   stb.rdSel = RS_CTRL;
        ADDR_W'(OFS_STAT):   stb.rdSel = RS_STAT;
        ADDR_W'(OFS_CMP_LO): stb.rdSel = RS_CMP_LO;
        ADDR_W'(OFS_CMP_HI): stb.rdSel = RS_CMP_HI;
        ADDR_W'(OFS_STEP):   stb.rdSel = RS_STEP;
        default:             stb.rdSel = RS_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl <= '0;
    end else if (ctrlWr) begin
      ctrl.tEn <= wrBits[0];
      ctrl.cEn <= wrBits[1];
      ctrl.iEn <= wrBits[2];
      ctrl.aEn <= wrBits[3];
    end
  end

  // R1: a write to an unmapped offset leaves the control bits alone
  p_unmapped_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && (busAddr > ADDR_W'(OFS_STEP))) |=> $stable(ctrl));
endmodule

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  ctrlBits_t         ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic [DATA_W-1:0] step;
  logic              flag;
  logic              spent;
  logic              hit;
  logic              cmpWr;

  assign cmpWr = stb.cmpLoWr || stb.cmpHiWr;
  assign hit   = ctrl.tEn && ctrl.cEn && !spent && (cnt >= cmp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.cntLoWr) begin
      cnt[DATA_W-1:0] <= wdata;
    end else if (stb.cntHiWr) begin
      cnt[CNT_W-1:DATA_W] <= wdata;
    end else if (ctrl.tEn) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmp   <= '0;
      spent <= 1'b0;
    end else if (cmpWr) begin
      if (stb.cmpLoWr) cmp[DATA_W-1:0]     <= wdata;
      if (stb.cmpHiWr) cmp[CNT_W-1:DATA_W] <= wdata;
      spent <= 1'b0;
    end else if (hit) begin
      if (ctrl.aEn) cmp <= cmp + CNT_W'(step);
      spent <= !ctrl.aEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step <= '0;
      flag <= 1'b0;
    end else begin
      if (stb.stepWr) step <= wdata;
      if (hit)              flag <= 1'b1;
      else if (stb.flagClr) flag <= 1'b0;
    end
  end

  always_comb begin
    case (stb.rdSel)
      RS_CNT_LO: rdata = cnt[DATA_W-1:0];
      RS_CNT_HI: rdata = cnt[CNT_W-1:DATA_W];
      RS_CTRL:   rdata = DATA_W'({ctrl.aEn, ctrl.iEn, ctrl.cEn, ctrl.tEn});
      RS_STAT:   rdata = DATA_W'(flag);
      RS_CMP_LO: rdata = cmp[DATA_W-1:0];
      RS_CMP_HI: rdata = cmp[CNT_W-1:DATA_W];
      RS_STEP:   rdata = step;
      default:   rdata = '0;
    endcase
  end

  assign irq = flag && ctrl.iEn;

  p_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.tEn && !stb.cntLoWr && !stb.cntHiWr) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.tEn && !stb.cntLoWr && !stb.cntHiWr) |=> $stable(cnt));

  p_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(ctrl.tEn && ctrl.cEn));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flagClr && !ctrl.cEn) |=> !flag);

  p_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hit && ctrl.aEn && !cmpWr) |=> (cmp == $past(cmp) + CNT_W'($past(step))));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmpWr && !ctrl.cEn) |=> !$rose(flag));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  strobe_t   stb;
  ctrlBits_t ctrl;

  cmp_timer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .wrBits (busWdata[3:0]),
    .stb    (stb),
    .ctrl   (ctrl)
  );

  cmp_timer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .ctrl (ctrl),
    .wdata(busWdata),
    .rdata(busRdata),
    .irq  (irqOut)
  );
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_ST = 5'h0C;
  localparam logic [4:0] A_MLO = 5'h10, A_MHI = 5'h14, A_INC = 5'h18, A_BAD = 5'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  cmp_timer u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 v = busRdata;
    busSel = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and R2 map
    for (int i = 0; i < 7; i++) rdChk("R1 reset reg", 5'(i * 4), 32'h0);
    chk("R1 reset irq", 32'(irqOut), 32'h0);
    wr(A_BAD, 32'hFFFF_FFFF);
    rdChk("R1 unmapped read", A_BAD, 32'h0);
    rdChk("R1 unmapped write ctrl", A_CTL, 32'h0);
    rdChk("R1 unmapped write cmp", A_MLO, 32'h0);

    // R4 preset, R3 carry into high half
    wr(A_CLO, 32'hFFFF_FFFE);
    wr(A_CHI, 32'h5);
    rdChk("R4 preset lo", A_CLO, 32'hFFFF_FFFE);
    rdChk("R4 preset hi", A_CHI, 32'h5);
    wr(A_CTL, 32'h1);
    rdChk("R2 ctrl readback", A_CTL, 32'h1);
    edges(1);
    rdChk("R3 count lo", A_CLO, 32'hFFFF_FFFF);
    rdChk("R3 count hi", A_CHI, 32'h5);
    edges(1);
    rdChk("R3 carry lo", A_CLO, 32'h0);
    rdChk("R3 carry hi", A_CHI, 32'h6);

    // R4 write beats increment
    wr(A_CLO, 32'h100);
    rdChk("R4 write priority", A_CLO, 32'h100);
    edges(3);
    rdChk("R3 after write", A_CLO, 32'h103);

    // R3 hold while disabled
    wr(A_CTL, 32'h0);
    rd(A_CLO, snap);
    edges(5);
    rdChk("R3 hold", A_CLO, snap);

    // R5 sweep of compare distances, with R9
    for (int c = 3; c < 9; c++) begin
      wr(A_CTL, 32'h0);
      wr(A_ST, 32'h1);
      wr(A_CLO, 32'h0);
      wr(A_CHI, 32'h0);
      wr(A_MLO, 32'(c));
      wr(A_MHI, 32'h0);
      wr(A_CTL, 32'h7);
      edges(c);
      rdChk("R5 not yet", A_ST, 32'h0);
      chk("R9 irq low", 32'(irqOut), 32'h0);
      edges(1);
      rdChk("R5 flag due", A_ST, 32'h1);
      chk("R9 irq high", 32'(irqOut), 32'h1);
    end

    // R7 spent compare, R6 clear
    wr(A_ST, 32'h0);
    rdChk("R6 write zero ignored", A_ST, 32'h1);
    wr(A_ST, 32'h1);
    rdChk("R6 cleared", A_ST, 32'h0);
    edges(8);
    rdChk("R7 no retrigger", A_ST, 32'h0);
    wr(A_MLO, 32'h5);
    rdChk("R7 rearm pending", A_ST, 32'h0);
    edges(1);
    rdChk("R7 rearm fires", A_ST, 32'h1);
    wr(A_ST, 32'h1);

    // R9 gating by interrupt enable
    wr(A_CTL, 32'h3);
    wr(A_MHI, 32'h0);
    edges(1);
    rdChk("R9 flag set", A_ST, 32'h1);
    chk("R9 irq masked", 32'(irqOut), 32'h0);
    wr(A_CTL, 32'h7);
    chk("R9 irq unmasked", 32'(irqOut), 32'h1);
    wr(A_ST, 32'h1);

    // R10 comparator writes while compare disabled
    wr(A_CTL, 32'h1);
    wr(A_ST, 32'h1);
    wr(A_MLO, 32'h0);
    edges(4);
    rdChk("R10 no flag", A_ST, 32'h0);
    chk("R10 no irq", 32'(irqOut), 32'h0);
    wr(A_CTL, 32'h3);
    edges(1);
    rdChk("R5 compare enable", A_ST, 32'h1);

    // R8 periodic sweep
    for (int p = 3; p < 9; p++) begin
      wr(A_CTL, 32'h0);
      wr(A_ST, 32'h1);
      wr(A_CLO, 32'h0);
      wr(A_CHI, 32'h0);
      wr(A_MLO, 32'd20);
      wr(A_MHI, 32'h0);
      wr(A_INC, 32'(p));
      wr(A_CTL, 32'hF);
      edges(20);
      rdChk("R8 first not yet", A_ST, 32'h0);
      edges(1);
      rdChk("R8 first event", A_ST, 32'h1);
      rdChk("R8 cmp stepped", A_MLO, 32'(20 + p));
      wr(A_ST, 32'h1);
      edges(p - 2);
      rdChk("R8 second not yet", A_ST, 32'h0);
      edges(1);
      rdChk("R8 second event", A_ST, 32'h1);
      rd(A_MLO, v);
      chk("R8 cmp stepped twice", v, 32'(20 + 2 * p));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule